// File: doc/BRIEF.md
# Windowed Frame Fetch Address Generator

This block produces the 32-bit-word byte addresses that a display fetch engine reads so that a rectangular window can be shown out of a larger frame buffer. Software loads a set of shadow settings: the window origin word, the bit position of the first pixel inside that word, the number of words in each window line, the word jump from one line to the next, the total words in the frame, a two-dimensional enable and a 24-bit packed pixel flag. Shadow settings stay inert until software raises a commit request. The next frame-start pulse then copies them into the working set, so the window can be moved from one frame to the next without changing a frame partway through.

While a frame runs, the block offers one address at a time on a valid/ready handshake, together with the first-pixel bit offset for a downstream unpacker. Once the programmed number of words has been accepted, it raises a one-cycle frame-done pulse and waits for the next frame start.

Top module: `wdma_top`

## Requirements
- R1: Synchronous active-high reset clears the working and shadow settings, disables two-dimensional mode and drives fetch_valid, frame_done, update_pending and cfg_error to 0. After reset the working frame size is 0.
- R2: A cfg_wr pulse only loads the shadow settings and the running frame never sees them. A cfg_update pulse sets update_pending in the following cycle. A frame_start pulse clears update_pending in the following cycle.
- R3: A frame_start copies the shadow set into the working set if a commit is pending, or if cfg_update is high in the same cycle. The cycle after a frame_start, fetch_addr equals the working origin with its two low bits forced to 0.
- R4: In two-dimensional mode with a line length L > 0, an accepted word that is the L-th word of its line makes the next address equal to that word's address plus 4 × stride. Every other accepted word advances the address by 4.
- R5: With two-dimensional mode off, every accepted word advances the address by 4, the stride and line length have no effect, and fetch_pix_off is 0.
- R6: In two-dimensional mode, fetch_pix_off equals the committed 5-bit first-pixel offset, unless R7 applies.
- R7: With two-dimensional mode and the 24-bit packed flag both set, an offset other than 0 or 8 raises cfg_error and drives fetch_pix_off to 0. Offsets 0 and 8 keep cfg_error low.
- R8: While fetch_valid is high and fetch_ready is low, fetch_valid stays high and fetch_addr is unchanged. The address and counters advance only on cycles where both are high.
- R9: Exactly frame-size words are offered per frame. The cycle after the last one is accepted, fetch_valid is 0 and frame_done is high for exactly one cycle. With a frame size of 0, a frame start offers no words and raises no frame_done.
- R10: A frame_start during a running frame restarts the fetch at the working origin. A window moved by a new commit takes effect at the next frame.
- R11: In two-dimensional mode with a line length of 0, no line jump happens and the address runs contiguously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Load all shadow settings from the cfg_* inputs |
| cfg_base | input | 32 | Byte address of the word holding the first window pixel |
| cfg_pix_off | input | 5 | Bit position of the first pixel within its word |
| cfg_stride | input | 16 | Word jump applied after the last word of a line |
| cfg_line_words | input | 12 | Words per window line (0 = no line jump) |
| cfg_frame_words | input | 20 | Words fetched per frame |
| cfg_en_2d | input | 1 | Two-dimensional window addressing enable |
| cfg_pack24 | input | 1 | 24-bit packed pixel format flag |
| cfg_update | input | 1 | Commit request for the shadow settings |
| frame_start | input | 1 | Frame boundary pulse |
| fetch_ready | input | 1 | Fetch engine accepts the current address |
| fetch_valid | output | 1 | An address is offered |
| fetch_addr | output | 32 | Word-aligned byte address to fetch |
| fetch_pix_off | output | 5 | First-pixel bit offset for the unpacker |
| frame_done | output | 1 | One-cycle pulse after the last word of a frame |
| cfg_error | output | 1 | Working set holds an illegal packed-24 offset |
| update_pending | output | 1 | A commit waits for the next frame start |

## Verification
Directed frames compare a two-dimensional window with a short line and a large stride against a contiguous run with the same stride and offset programmed. Any wrong gating by the enable shows up as a line jump or a non-zero offset where none belongs. Packed-24 frames with offsets 16, 8 and 0 separate the error path from legal values. A line length of 0 and frame sizes of 0 and 1 cover the edges of the line and frame counters. A shadow write without a commit, and a restart partway through a frame, separate the shadow and working sets. Random configurations with a fixed seed and a random ready duty cycle move the window on every frame, and every offered address is compared against a bench model, including during stalls.

// File: rtl/wdma_pkg.sv
package wdma_pkg;

    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned OFF_W      = 5;
    localparam int unsigned STRIDE_W   = 16;
    localparam int unsigned LINE_W     = 12;
    localparam int unsigned FRAME_W    = 20;
    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned WB_LOG2    = $clog2(WORD_BYTES);

    localparam logic [OFF_W-1:0] P24_OFF_LO = OFF_W'(0);
    localparam logic [OFF_W-1:0] P24_OFF_HI = OFF_W'(8);

    typedef struct packed {
        logic [ADDR_W-1:0]   base;
        logic [OFF_W-1:0]    pix_off;
        logic [STRIDE_W-1:0] stride;
        logic [LINE_W-1:0]   line_words;
        logic [FRAME_W-1:0]  frame_words;
        logic                en_2d;
        logic                pack24;
    } wdma_cfg_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } wdma_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LINE_W-1:0] line_idx;
    } wdma_pos_t;

    function automatic logic off_legal(wdma_cfg_t c);
        if (c.en_2d && c.pack24)
            return (c.pix_off == P24_OFF_LO) || (c.pix_off == P24_OFF_HI);
        return 1'b1;
    endfunction

    function automatic logic [OFF_W-1:0] eff_offset(wdma_cfg_t c);
        if (c.en_2d && off_legal(c))
            return c.pix_off;
        return '0;
    endfunction

    function automatic logic [ADDR_W-1:0] word_align(logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:WB_LOG2], {WB_LOG2{1'b0}}};
    endfunction

    function automatic logic [ADDR_W-1:0] words_to_bytes(logic [STRIDE_W-1:0] w);
        return ADDR_W'(w) << WB_LOG2;
    endfunction

endpackage

// File: rtl/wdma_cfg_bank.sv
module wdma_cfg_bank
    import wdma_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cfg_wr,
    input  wdma_cfg_t cfg_in,
    input  logic      cfg_update,
    input  logic      frame_start,
    output wdma_cfg_t act_cfg,
    output wdma_cfg_t start_cfg,
    output logic      upd_pend,
    output logic      cfg_err
);

    wdma_cfg_t shadow_q;
    wdma_cfg_t active_q;
    logic      pend_q;
    logic      commit;

    assign commit = frame_start && (pend_q || cfg_update);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
        end else if (cfg_wr) begin
            shadow_q <= cfg_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= '0;
        end else if (commit) begin
            active_q <= shadow_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (frame_start) begin
            pend_q <= 1'b0;
        end else if (cfg_update) begin
            pend_q <= 1'b1;
        end
    end

    assign act_cfg   = active_q;
    assign start_cfg = commit ? shadow_q : active_q;
    assign upd_pend  = pend_q;
    assign cfg_err   = !off_legal(active_q);

endmodule

// File: rtl/wdma_step.sv
module wdma_step
    import wdma_pkg::*;
(
    input  wdma_pos_t pos,
    input  wdma_cfg_t cfg,
    output wdma_pos_t nxt,
    output logic      line_end
);

    logic [LINE_W-1:0] last_idx;

    assign last_idx = cfg.line_words - LINE_W'(1);
    assign line_end = cfg.en_2d && (cfg.line_words != '0) && (pos.line_idx == last_idx);

    always_comb begin
        if (line_end) begin
            nxt.addr     = pos.addr + words_to_bytes(cfg.stride);
            nxt.line_idx = '0;
        end else begin
            nxt.addr     = pos.addr + ADDR_W'(WORD_BYTES);
            nxt.line_idx = pos.line_idx + LINE_W'(1);
        end
    end

endmodule

// File: rtl/wdma_seq.sv
module wdma_seq
    import wdma_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_start,
    input  logic               ready,
    input  logic [ADDR_W-1:0]  start_base,
    input  logic [FRAME_W-1:0] start_frame_words,
    input  logic [FRAME_W-1:0] act_frame_words,
    input  wdma_pos_t          nxt_pos,
    output wdma_pos_t          cur_pos,
    output logic               valid,
    output logic               done
);

    wdma_state_e        state_q;
    wdma_pos_t          pos_q;
    logic [FRAME_W-1:0] cnt_q;
    logic [FRAME_W-1:0] cnt_inc;
    logic               done_q;

    assign cnt_inc = cnt_q + FRAME_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (frame_start) begin
                pos_q.addr     <= word_align(start_base);
                pos_q.line_idx <= '0;
                cnt_q          <= '0;
                state_q        <= (start_frame_words != '0) ? ST_RUN : ST_IDLE;
            end else if (state_q == ST_RUN && ready) begin
                pos_q <= nxt_pos;
                cnt_q <= cnt_inc;
                if (cnt_inc == act_frame_words) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    assign cur_pos = pos_q;
    assign valid   = (state_q == ST_RUN);
    assign done    = done_q;

endmodule

// File: rtl/wdma_top.sv
module wdma_top
    import wdma_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr,
    input  logic [ADDR_W-1:0]   cfg_base,
    input  logic [OFF_W-1:0]    cfg_pix_off,
    input  logic [STRIDE_W-1:0] cfg_stride,
    input  logic [LINE_W-1:0]   cfg_line_words,
    input  logic [FRAME_W-1:0]  cfg_frame_words,
    input  logic                cfg_en_2d,
    input  logic                cfg_pack24,
    input  logic                cfg_update,
    input  logic                frame_start,
    input  logic                fetch_ready,
    output logic                fetch_valid,
    output logic [ADDR_W-1:0]   fetch_addr,
    output logic [OFF_W-1:0]    fetch_pix_off,
    output logic                frame_done,
    output logic                cfg_error,
    output logic                update_pending
);

    wdma_cfg_t cfg_in;
    wdma_cfg_t act_cfg;
    wdma_cfg_t start_cfg;
    wdma_pos_t cur_pos;
    wdma_pos_t nxt_pos;
    logic      line_end;

    always_comb begin
        cfg_in.base        = cfg_base;
        cfg_in.pix_off     = cfg_pix_off;
        cfg_in.stride      = cfg_stride;
        cfg_in.line_words  = cfg_line_words;
        cfg_in.frame_words = cfg_frame_words;
        cfg_in.en_2d       = cfg_en_2d;
        cfg_in.pack24      = cfg_pack24;
    end

    wdma_cfg_bank u_cfg (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr     (cfg_wr),
        .cfg_in     (cfg_in),
        .cfg_update (cfg_update),
        .frame_start(frame_start),
        .act_cfg    (act_cfg),
        .start_cfg  (start_cfg),
        .upd_pend   (update_pending),
        .cfg_err    (cfg_error)
    );

    wdma_step u_step (
        .pos     (cur_pos),
        .cfg     (act_cfg),
        .nxt     (nxt_pos),
        .line_end(line_end)
    );

    wdma_seq u_seq (
        .clk              (clk),
        .rst              (rst),
        .frame_start      (frame_start),
        .ready            (fetch_ready),
        .start_base       (start_cfg.base),
        .start_frame_words(start_cfg.frame_words),
        .act_frame_words  (act_cfg.frame_words),
        .nxt_pos          (nxt_pos),
        .cur_pos          (cur_pos),
        .valid            (fetch_valid),
        .done             (frame_done)
    );

    assign fetch_addr    = cur_pos.addr;
    assign fetch_pix_off = eff_offset(act_cfg);

    logic unused_ok;
    assign unused_ok = line_end;

endmodule

// File: rtl/wdma_chk.sv
module wdma_chk
    import wdma_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_update,
    input logic              frame_start,
    input logic              fetch_ready,
    input logic              fetch_valid,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic [OFF_W-1:0]  fetch_pix_off,
    input logic              frame_done,
    input logic              cfg_error,
    input logic              update_pending
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!fetch_valid && !frame_done && !update_pending && !cfg_error));

    // R2
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_update && !frame_start) |=> update_pending);

    // R2
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !update_pending);

    // R7
    err_zero_off_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_error |-> (fetch_pix_off == '0));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && !fetch_ready && !frame_start) |=> (fetch_valid && $stable(fetch_addr)));

    // R8
    addr_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_valid |-> (fetch_addr[WB_LOG2-1:0] == '0));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    // R9
    done_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> ($past(fetch_valid && fetch_ready) && !fetch_valid));

endmodule

bind wdma_top wdma_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_update    (cfg_update),
    .frame_start   (frame_start),
    .fetch_ready   (fetch_ready),
    .fetch_valid   (fetch_valid),
    .fetch_addr    (fetch_addr),
    .fetch_pix_off (fetch_pix_off),
    .frame_done    (frame_done),
    .cfg_error     (cfg_error),
    .update_pending(update_pending)
);

// File: tb/wdma_top_tb.sv
`timescale 1ns/1ps
module wdma_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [4:0]  cfg_pix_off = '0;
    logic [15:0] cfg_stride = '0;
    logic [11:0] cfg_line_words = '0;
    logic [19:0] cfg_frame_words = '0;
    logic        cfg_en_2d = 1'b0;
    logic        cfg_pack24 = 1'b0;
    logic        cfg_update = 1'b0;
    logic        frame_start = 1'b0;
    logic        fetch_ready = 1'b0;
    logic        fetch_valid;
    logic [31:0] fetch_addr;
    logic [4:0]  fetch_pix_off;
    logic        frame_done;
    logic        cfg_error;
    logic        update_pending;

    always #2 clk = ~clk;

    wdma_top u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_base(cfg_base),
        .cfg_pix_off(cfg_pix_off), .cfg_stride(cfg_stride),
        .cfg_line_words(cfg_line_words), .cfg_frame_words(cfg_frame_words),
        .cfg_en_2d(cfg_en_2d), .cfg_pack24(cfg_pack24), .cfg_update(cfg_update),
        .frame_start(frame_start), .fetch_ready(fetch_ready),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .fetch_pix_off(fetch_pix_off), .frame_done(frame_done),
        .cfg_error(cfg_error), .update_pending(update_pending)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // bench copies of shadow and working settings
    logic [31:0] p_base = '0, a_base = '0;
    logic [4:0]  p_off = '0,  a_off = '0;
    logic [15:0] p_str = '0,  a_str = '0;
    logic [11:0] p_lw = '0,   a_lw = '0;
    logic [19:0] p_fw = '0,   a_fw = '0;
    bit          p_2d = 0,    a_2d = 0;
    bit          p_24 = 0,    a_24 = 0;
    bit          m_upd = 0;

    logic [31:0] m_addr = '0;
    logic [11:0] m_line = '0;
    logic [19:0] m_cnt = '0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_err();
        return a_2d && a_24 && (a_off != 5'd0) && (a_off != 5'd8);
    endfunction

    function automatic logic [4:0] exp_off();
        return (a_2d && !exp_err()) ? a_off : 5'd0;
    endfunction

    task automatic model_advance();
        if (a_2d && a_lw != 0 && m_line == a_lw - 12'd1) begin
            m_addr = m_addr + {14'd0, a_str, 2'b00};
            m_line = '0;
        end else begin
            m_addr = m_addr + 32'd4;
            m_line = m_line + 12'd1;
        end
        m_cnt = m_cnt + 20'd1;
    endtask

    task automatic write_cfg(input logic [31:0] b, input logic [4:0] o, input logic [15:0] s,
                             input logic [11:0] lw, input logic [19:0] fw, input bit e2, input bit p24);
        @(negedge clk);
        cfg_base = b; cfg_pix_off = o; cfg_stride = s; cfg_line_words = lw;
        cfg_frame_words = fw; cfg_en_2d = e2; cfg_pack24 = p24; cfg_wr = 1'b1;
        p_base = b; p_off = o; p_str = s; p_lw = lw; p_fw = fw; p_2d = e2; p_24 = p24;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse_update();
        @(negedge clk);
        cfg_update = 1'b1;
        @(negedge clk);
        cfg_update = 1'b0;
        m_upd = 1;
        chk(update_pending == 1'b1, "R2 pending set", update_pending, 1);
    endtask

    task automatic start_frame();
        @(negedge clk);
        frame_start = 1'b1;
        if (m_upd) begin
            a_base = p_base; a_off = p_off; a_str = p_str; a_lw = p_lw;
            a_fw = p_fw; a_2d = p_2d; a_24 = p_24; m_upd = 0;
        end
        m_addr = {a_base[31:2], 2'b00};
        m_line = '0;
        m_cnt = '0;
        @(negedge clk);
        frame_start = 1'b0;
        chk(update_pending == 1'b0, "R2 pending cleared", update_pending, 0);
        chk(fetch_valid == (a_fw != 0), "R9 valid after start", fetch_valid, a_fw != 0);
        if (a_fw != 0)
            chk(fetch_addr == m_addr, "R3 first address at origin", fetch_addr, m_addr);
        chk(cfg_error == exp_err(), "R7 error flag", cfg_error, exp_err());
    endtask

    // Runs the handshake until limit words are accepted or the frame ends.
    task automatic run_words(input int pct, input int limit);
        int guard = 0;
        while (m_cnt < a_fw && m_cnt < limit && guard < 5000) begin
            bit rd = (($urandom % 100) < pct);
            guard++;
            fetch_ready = rd;
            chk(fetch_valid == 1'b1, "R8 valid held", fetch_valid, 1);
            chk(fetch_addr == m_addr, a_2d ? "R4 2D address" : "R5 contiguous address", fetch_addr, m_addr);
            chk(fetch_pix_off == exp_off(), "R6 offset passthrough", fetch_pix_off, exp_off());
            @(negedge clk);
            if (rd) model_advance();
        end
        fetch_ready = 1'b0;
        if (m_cnt == a_fw && a_fw != 0) begin
            chk(frame_done == 1'b1, "R9 done pulse", frame_done, 1);
            chk(fetch_valid == 1'b0, "R9 valid low after frame", fetch_valid, 0);
            @(negedge clk);
            chk(frame_done == 1'b0, "R9 done one cycle", frame_done, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_2d01));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(fetch_valid == 0, "R1 valid", fetch_valid, 0);
        chk(frame_done == 0, "R1 done", frame_done, 0);
        chk(update_pending == 0, "R1 pending", update_pending, 0);
        chk(cfg_error == 0, "R1 error", cfg_error, 0);
        chk(fetch_pix_off == 0, "R1 offset", fetch_pix_off, 0);

        // R2: shadow write without commit has no effect
        write_cfg(32'h0000_1000, 5'd12, 16'd10, 12'd3, 20'd9, 1, 0);
        start_frame();
        repeat (3) begin
            @(negedge clk);
            chk(fetch_valid == 0, "R2 shadow inert", fetch_valid, 0);
            chk(fetch_pix_off == 0, "R2 shadow offset inert", fetch_pix_off, 0);
        end

        // R3 R4 R6: commit then 2D window
        pulse_update();
        repeat (2) @(negedge clk);
        chk(update_pending == 1, "R2 pending holds", update_pending, 1);
        chk(fetch_valid == 0, "R2 no commit before frame start", fetch_valid, 0);
        start_frame();
        run_words(100, 1 << 20);

        // R8 stalls with same window
        start_frame();
        run_words(30, 1 << 20);

        // R5 contiguous with stride and offset programmed
        write_cfg(32'h0000_2003, 5'd12, 16'd50, 12'd2, 20'd7, 0, 0);
        pulse_update();
        start_frame();
        run_words(60, 1 << 20);

        // R7 packed-24 offsets
        write_cfg(32'h0000_3000, 5'd16, 16'd4, 12'd2, 20'd5, 1, 1);
        pulse_update();
        start_frame();
        chk(cfg_error == 1, "R7 illegal offset flagged", cfg_error, 1);
        run_words(80, 1 << 20);
        write_cfg(32'h0000_3000, 5'd8, 16'd4, 12'd2, 20'd5, 1, 1);
        pulse_update();
        start_frame();
        chk(cfg_error == 0, "R7 offset 8 legal", cfg_error, 0);
        chk(fetch_pix_off == 8, "R7 offset 8 passed", fetch_pix_off, 8);
        run_words(80, 1 << 20);
        write_cfg(32'h0000_3000, 5'd0, 16'd4, 12'd2, 20'd5, 1, 1);
        pulse_update();
        start_frame();
        chk(cfg_error == 0, "R7 offset 0 legal", cfg_error, 0);
        run_words(80, 1 << 20);

        // R11 line length zero
        write_cfg(32'h0000_4000, 5'd4, 16'd99, 12'd0, 20'd6, 1, 0);
        pulse_update();
        start_frame();
        run_words(70, 1 << 20);

        // R9 frame size 0 and 1
        write_cfg(32'h0000_5000, 5'd0, 16'd1, 12'd1, 20'd0, 1, 0);
        pulse_update();
        start_frame();
        repeat (3) begin
            @(negedge clk);
            chk(fetch_valid == 0 && frame_done == 0, "R9 zero frame idle", {fetch_valid, frame_done}, 0);
        end
        write_cfg(32'h0000_5000, 5'd0, 16'd1, 12'd1, 20'd1, 1, 0);
        pulse_update();
        start_frame();
        run_words(100, 1 << 20);

        // R10 restart mid-frame
        write_cfg(32'h0000_6000, 5'd2, 16'd8, 12'd2, 20'd10, 1, 0);
        pulse_update();
        start_frame();
        run_words(100, 3);
        start_frame();
        chk(fetch_addr == 32'h0000_6000, "R10 restart at origin", fetch_addr, 32'h0000_6000);
        run_words(100, 1 << 20);

        // R10 random window moves each frame
        for (int i = 0; i < 25; i++) begin
            write_cfg({16'h0001, 16'($urandom)}, 5'($urandom), 16'($urandom % 64),
                      12'($urandom % 8), 20'(1 + $urandom % 40), 1'($urandom), 1'($urandom));
            pulse_update();
            start_frame();
            run_words(20 + int'($urandom % 80), 1 << 20);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule